// File: doc/BRIEF.md
# Converter Start and Busy Sequencer

This block is the digital sequencer in front of a 16-bit successive-approximation converter. It watches two active-low host strobes, read/convert and chip select. From them it decides whether the host wants a new conversion or wants the last result read out. A conversion is requested when the logical OR of the two strobes goes low. That moment is set by whichever strobe falls second, in either order. Before a start is accepted, two timing rules are checked in system-clock cycles. The two falls must be far enough apart, and the combined low must last long enough.

An accepted start raises a one-cycle hold strobe toward the sampler and drives the active-low busy output low. It then runs a fixed-length timer that stands in for the analog core. When the timer expires, the word on the result input is latched into the output register and a valid flag is set. Busy then returns high. A request that breaks a timing rule is dropped and counted in a saturating error counter.

Requests that arrive during a conversion are dropped without being counted. A power-down input blocks new conversions and aborts one in flight, and the last latched word is kept. Every asynchronous input passes through a two-flop synchronizer before any edge is detected. Serial shifting of the result is left to a downstream block, which receives a read-request pulse.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy_n_o is 1, hold_o is 0, rd_req_o is 0, rslt_vld_o is 0, rslt_o is 0 and err_cnt_o is 0.
- R2: A start is accepted when the OR of rdcv_n_i and csel_n_i falls, in either order of the two strobes. The two falls must lie at least MIN_SEP_CYC sampled cycles apart, and the OR must stay low for at least MIN_LOW_CYC sampled cycles. Exactly one conversion results.
- R3: An accepted conversion holds busy_n_o low for exactly CONV_CYC cycles. On its final cycle, result_i is loaded into rslt_o and rslt_vld_o becomes 1. rslt_vld_o never clears again.
- R4: If the combined low ends before MIN_LOW_CYC sampled cycles, no conversion starts and err_cnt_o increments by one.
- R5: If the two falls are fewer than MIN_SEP_CYC cycles apart, no conversion starts and err_cnt_o increments by one. Falls in the same cycle count as zero cycles apart.
- R6: A combined fall while busy_n_o is low is ignored. It causes no extra hold pulse and no error, and the running conversion keeps its full length.
- R7: While pwrdn_i is high, a combined fall is ignored without error. A rise of pwrdn_i during a conversion ends it early with busy_n_o back to 1. In both cases rslt_o and rslt_vld_o keep their previous values.
- R8: rd_req_o pulses for one cycle in two cases: csel_n_i falls while rdcv_n_i is high, or rdcv_n_i rises while csel_n_i is low. The pulse is suppressed when that rise ends a start that is still being qualified.
- R9: err_cnt_o counts one per rejected start and saturates at its all-ones value.
- R10: hold_o is a single-cycle pulse. It is high in exactly the first cycle that busy_n_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdcv_n_i | input | 1 | Read/convert strobe, asynchronous |
| csel_n_i | input | 1 | Chip-select strobe, active low, asynchronous |
| pwrdn_i | input | 1 | Power-down request, asynchronous |
| result_i | input | DATA_W | Conversion word from the analog core |
| hold_o | output | 1 | One-cycle hold strobe to the sampler |
| busy_n_o | output | 1 | Low while a conversion runs |
| rd_req_o | output | 1 | One-cycle read request to the serializer |
| rslt_o | output | DATA_W | Last latched conversion word |
| rslt_vld_o | output | 1 | A conversion has completed since reset |
| err_cnt_o | output | ERR_W | Saturating count of rejected starts |

## Verification
Two functions can fall in the same cycle. A rising read/convert strobe can end a start that is still being qualified, which makes it both a read edge and a width violation. A power-down rise can also arrive while a conversion is still counting. The bench provokes the first by releasing the strobe one or two cycles short of the minimum with chip select held low. It judges the outcome by a read-request count that does not advance and an error count that advances by one. The second is provoked by raising power-down a few cycles into a conversion. It is judged by a busy run shorter than the conversion length and a result register that still shows the previous word.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_CONV = 2'd2
    } seq_state_e;

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] q;
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= g_stage[g-1].q;
            end
        end
    end

    assign dout = g_stage[STAGES-1].q;

endmodule

// File: rtl/adc_seq_strobe.sv
module adc_seq_strobe #(
    parameter int MIN_SEP_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rc_s,
    input  logic cs_s,
    output logic comb_fall,
    output logic comb_low,
    output logic sep_ok,
    output logic rd_edge
);

    localparam int AGE_W = (MIN_SEP_CYC < 1) ? 1 : $clog2(MIN_SEP_CYC + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(MIN_SEP_CYC);

    typedef struct packed {
        logic             rc;
        logic             cs;
        logic [AGE_W-1:0] age;
    } strobe_t;

    strobe_t cur_q, nxt_d;

    logic rc_fell, cs_fell, rc_rose, one_fell;

    always_comb begin
        rc_fell  = cur_q.rc & ~rc_s;
        cs_fell  = cur_q.cs & ~cs_s;
        rc_rose  = ~cur_q.rc & rc_s;
        one_fell = rc_fell ^ cs_fell;

        comb_low  = ~(rc_s | cs_s);
        comb_fall = (cur_q.rc | cur_q.cs) & comb_low;
        sep_ok    = one_fell & (cur_q.age >= AGE_MAX);
        rd_edge   = (cs_fell & rc_s) | (rc_rose & ~cs_s);

        nxt_d    = cur_q;
        nxt_d.rc = rc_s;
        nxt_d.cs = cs_s;
        if ((rc_fell & cs_s) | (cs_fell & rc_s)) begin
            nxt_d.age = AGE_W'(1);
        end else if ((rc_s ^ cs_s) && (cur_q.age < AGE_MAX)) begin
            nxt_d.age = cur_q.age + AGE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.rc  <= 1'b1;
            cur_q.cs  <= 1'b1;
            cur_q.age <= AGE_MAX;
        end else begin
            cur_q <= nxt_d;
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
    parameter int DATA_W      = 16,
    parameter int CONV_CYC    = 24,
    parameter int MIN_LOW_CYC = 5,
    parameter int MIN_SEP_CYC = 2,
    parameter int ERR_W       = 8,
    parameter int SYNC_STG    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rdcv_n_i,
    input  logic              csel_n_i,
    input  logic              pwrdn_i,
    input  logic [DATA_W-1:0] result_i,
    output logic              hold_o,
    output logic              busy_n_o,
    output logic              rd_req_o,
    output logic [DATA_W-1:0] rslt_o,
    output logic              rslt_vld_o,
    output logic [ERR_W-1:0]  err_cnt_o
);
    import adc_seq_pkg::*;

    localparam int LOW_W  = (MIN_LOW_CYC < 2) ? 1 : $clog2(MIN_LOW_CYC);
    localparam int CONV_W = $clog2(CONV_CYC + 1);
    localparam logic [LOW_W-1:0]  LOW_LAST  = LOW_W'(MIN_LOW_CYC - 1);
    localparam logic [CONV_W-1:0] CONV_LAST = CONV_W'(CONV_CYC);

    typedef struct packed {
        seq_state_e        state;
        logic [LOW_W-1:0]  low_cnt;
        logic [CONV_W-1:0] conv_cnt;
        logic [DATA_W-1:0] rslt;
        logic              vld;
        logic [ERR_W-1:0]  err;
        logic              hold;
        logic              busy_n;
        logic              rd_req;
    } seq_t;

    logic [2:0] raw_in, syn_in;
    logic       rc_s, cs_s, pd_s;
    logic       comb_fall, comb_low, sep_ok, rd_edge;

    assign raw_in = {pwrdn_i, csel_n_i, rdcv_n_i};

    adc_seq_sync #(
        .W       (3),
        .STAGES  (SYNC_STG),
        .RST_VAL (3'b011)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .dout  (syn_in)
    );

    assign rc_s = syn_in[0];
    assign cs_s = syn_in[1];
    assign pd_s = syn_in[2];

    adc_seq_strobe #(
        .MIN_SEP_CYC (MIN_SEP_CYC)
    ) i_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .rc_s      (rc_s),
        .cs_s      (cs_s),
        .comb_fall (comb_fall),
        .comb_low  (comb_low),
        .sep_ok    (sep_ok),
        .rd_edge   (rd_edge)
    );

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d        = cur_q;
        nxt_d.hold   = 1'b0;
        nxt_d.rd_req = rd_edge & (cur_q.state != ST_PEND);

        unique case (cur_q.state)
            ST_IDLE: begin
                if (comb_fall && !pd_s) begin
                    if (sep_ok) begin
                        nxt_d.state   = ST_PEND;
                        nxt_d.low_cnt = LOW_W'(1);
                    end else if (cur_q.err != '1) begin
                        nxt_d.err = cur_q.err + ERR_W'(1);
                    end
                end
            end
            ST_PEND: begin
                if (pd_s) begin
                    nxt_d.state = ST_IDLE;
                end else if (!comb_low) begin
                    nxt_d.state = ST_IDLE;
                    if (cur_q.err != '1) nxt_d.err = cur_q.err + ERR_W'(1);
                end else if (cur_q.low_cnt == LOW_LAST) begin
                    nxt_d.state    = ST_CONV;
                    nxt_d.conv_cnt = CONV_W'(1);
                    nxt_d.hold     = 1'b1;
                    nxt_d.busy_n   = 1'b0;
                end else begin
                    nxt_d.low_cnt = cur_q.low_cnt + LOW_W'(1);
                end
            end
            ST_CONV: begin
                if (pd_s) begin
                    nxt_d.state  = ST_IDLE;
                    nxt_d.busy_n = 1'b1;
                end else if (cur_q.conv_cnt == CONV_LAST) begin
                    nxt_d.state  = ST_IDLE;
                    nxt_d.busy_n = 1'b1;
                    nxt_d.rslt   = result_i;
                    nxt_d.vld    = 1'b1;
                end else begin
                    nxt_d.conv_cnt = cur_q.conv_cnt + CONV_W'(1);
                end
            end
            default: begin
                nxt_d.state  = ST_IDLE;
                nxt_d.busy_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state    <= ST_IDLE;
            cur_q.low_cnt  <= '0;
            cur_q.conv_cnt <= '0;
            cur_q.rslt     <= '0;
            cur_q.vld      <= 1'b0;
            cur_q.err      <= '0;
            cur_q.hold     <= 1'b0;
            cur_q.busy_n   <= 1'b1;
            cur_q.rd_req   <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign hold_o     = cur_q.hold;
    assign busy_n_o   = cur_q.busy_n;
    assign rd_req_o   = cur_q.rd_req;
    assign rslt_o     = cur_q.rslt;
    assign rslt_vld_o = cur_q.vld;
    assign err_cnt_o  = cur_q.err;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
    parameter int DATA_W   = 16,
    parameter int CONV_CYC = 24,
    parameter int ERR_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold_o,
    input logic              busy_n_o,
    input logic [DATA_W-1:0] rslt_o,
    input logic              rslt_vld_o,
    input logic [ERR_W-1:0]  err_cnt_o
);

    localparam int RUN_W = $clog2(CONV_CYC + 2);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             run_q <= '0;
        else if (busy_n_o)      run_q <= '0;
        else if (run_q != '1)   run_q <= run_q + RUN_W'(1);
    end

    assert_hold_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> !busy_n_o);

    assert_hold_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |=> !hold_o);

    assert_busy_fall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_n_o) |-> hold_o);

    assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n_o) |-> (run_q <= RUN_W'(CONV_CYC)));

    assert_vld_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rslt_vld_o |=> rslt_vld_o);

    assert_rslt_only_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rslt_o) |-> $rose(busy_n_o));

    assert_err_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_cnt_o) |-> (err_cnt_o == $past(err_cnt_o) + ERR_W'(1)));

    assert_err_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_cnt_o) == '1) |-> (err_cnt_o == '1));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .DATA_W   (DATA_W),
    .CONV_CYC (CONV_CYC),
    .ERR_W    (ERR_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_o     (hold_o),
    .busy_n_o   (busy_n_o),
    .rslt_o     (rslt_o),
    .rslt_vld_o (rslt_vld_o),
    .err_cnt_o  (err_cnt_o)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;

    localparam int DW    = 16;
    localparam int CONV  = 24;
    localparam int MLOW  = 5;
    localparam int MSEP  = 2;
    localparam int EW    = 4;
    localparam int EMAX  = (1 << EW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rdcv_n = 1'b1;
    logic          csel_n = 1'b1;
    logic          pwrdn = 1'b0;
    logic [DW-1:0] result = '0;
    logic          hold, busy_n, rd_req, vld;
    logic [DW-1:0] rslt;
    logic [EW-1:0] err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int hold_cnt = 0;
    int rd_cnt = 0;
    int run = 0;
    int last_len = 0;
    int hold_bad = 0;
    bit hold_prev = 0;

    int exp_err = 0;
    logic [DW-1:0] exp_rslt = '0;

    always #5 clk = ~clk;

    adc_seq_ctrl #(
        .DATA_W      (DW),
        .CONV_CYC    (CONV),
        .MIN_LOW_CYC (MLOW),
        .MIN_SEP_CYC (MSEP),
        .ERR_W       (EW)
    ) i_adc_seq_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rdcv_n_i   (rdcv_n),
        .csel_n_i   (csel_n),
        .pwrdn_i    (pwrdn),
        .result_i   (result),
        .hold_o     (hold),
        .busy_n_o   (busy_n),
        .rd_req_o   (rd_req),
        .rslt_o     (rslt),
        .rslt_vld_o (vld),
        .err_cnt_o  (err)
    );

    // observers, sampled away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold) hold_cnt++;
            if (rd_req) rd_cnt++;
            if (hold && (busy_n || hold_prev)) hold_bad++;
            hold_prev = hold;
            if (!busy_n) run++;
            else if (run > 0) begin
                last_len = run;
                run = 0;
            end
        end
    end

    function automatic bit start_ok(int sep, int width);
        return (sep >= MSEP) && (width >= MLOW);
    endfunction

    function automatic int err_after(int e);
        return (e >= EMAX) ? EMAX : e + 1;
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // second strobe falls sep cycles after the first, both held low width cycles
    task automatic start_seq(bit cs_first, int sep, int width);
        @(negedge clk);
        if (sep == 0) begin
            rdcv_n = 1'b0;
            csel_n = 1'b0;
        end else begin
            if (cs_first) csel_n = 1'b0; else rdcv_n = 1'b0;
            repeat (sep) @(negedge clk);
            if (cs_first) rdcv_n = 1'b0; else csel_n = 1'b0;
        end
        repeat (width) @(negedge clk);
        rdcv_n = 1'b1;
        csel_n = 1'b1;
    endtask

    task automatic settle();
        repeat (CONV + 14) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int h0, r0;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // R1 reset state
        chk("R1 busy_n", busy_n, 1);
        chk("R1 hold", hold, 0);
        chk("R1 rd_req", rd_req, 0);
        chk("R1 valid", vld, 0);
        chk("R1 result", rslt, 0);
        chk("R1 errors", err, 0);

        // R2/R3 rdcv first, minimum width and separation
        result = 16'hA5C3;
        h0 = hold_cnt; r0 = rd_cnt;
        start_seq(0, MSEP, MLOW);
        settle();
        exp_rslt = 16'hA5C3;
        chk("R2 one hold", hold_cnt - h0, 1);
        chk("R3 busy length", last_len, CONV);
        chk("R3 result", rslt, exp_rslt);
        chk("R3 valid", vld, 1);
        chk("R8 no read with rdcv first", rd_cnt - r0, 0);

        // R2 csel first: csel fall with rdcv high also asks for a read (R8)
        result = 16'h0F1E;
        h0 = hold_cnt; r0 = rd_cnt;
        start_seq(1, MSEP + 1, MLOW + 2);
        settle();
        exp_rslt = 16'h0F1E;
        chk("R2 csel-first hold", hold_cnt - h0, 1);
        chk("R3 csel-first result", rslt, exp_rslt);
        chk("R8 csel fall read", rd_cnt - r0, 1);

        // R4 width one short
        h0 = hold_cnt;
        start_seq(0, MSEP, MLOW - 1);
        settle();
        exp_err = err_after(exp_err);
        chk("R4 no hold", hold_cnt - h0, 0);
        chk("R4 error count", err, exp_err);
        chk("R4 result kept", rslt, exp_rslt);

        // R5 simultaneous falls and one-cycle separation
        h0 = hold_cnt;
        start_seq(0, 0, MLOW + 3);
        settle();
        exp_err = err_after(exp_err);
        chk("R5 same-cycle no hold", hold_cnt - h0, 0);
        chk("R5 same-cycle error", err, exp_err);
        start_seq(1, MSEP - 1, MLOW + 3);
        settle();
        exp_err = err_after(exp_err);
        chk("R5 short separation no hold", hold_cnt - h0, 0);
        chk("R5 short separation error", err, exp_err);

        // R8 rdcv rising with csel low after an accepted start; suppressed on short pulse
        result = 16'h3C3C;
        r0 = rd_cnt; h0 = hold_cnt;
        @(negedge clk); csel_n = 1'b0;
        repeat (3) @(negedge clk); rdcv_n = 1'b0;
        repeat (MLOW + 2) @(negedge clk); rdcv_n = 1'b1;
        repeat (4) @(negedge clk); csel_n = 1'b1;
        settle();
        exp_rslt = 16'h3C3C;
        chk("R8 two reads", rd_cnt - r0, 2);
        chk("R2 csel held low start", hold_cnt - h0, 1);
        r0 = rd_cnt;
        @(negedge clk); csel_n = 1'b0;
        repeat (3) @(negedge clk); rdcv_n = 1'b0;
        repeat (MLOW - 2) @(negedge clk); rdcv_n = 1'b1;
        repeat (4) @(negedge clk); csel_n = 1'b1;
        settle();
        exp_err = err_after(exp_err);
        chk("R8 read suppressed while qualifying", rd_cnt - r0, 1);
        chk("R4 short pulse error", err, exp_err);

        // R6 start sequence during a conversion
        result = 16'h7777;
        h0 = hold_cnt;
        start_seq(0, MSEP + 1, MLOW + 1);
        start_seq(0, MSEP + 1, MLOW + 1);
        settle();
        exp_rslt = 16'h7777;
        chk("R6 single hold", hold_cnt - h0, 1);
        chk("R6 full busy length", last_len, CONV);
        chk("R6 no error", err, exp_err);

        // R7 power-down abort then blocked start
        result = 16'hDEAD;
        h0 = hold_cnt;
        start_seq(0, MSEP + 1, MLOW + 1);
        repeat (2) @(negedge clk);
        pwrdn = 1'b1;
        settle();
        chk("R7 abort busy high", busy_n, 1);
        chk("R7 abort short run", (last_len < CONV), 1);
        chk("R7 result kept", rslt, exp_rslt);
        chk("R7 valid kept", vld, 1);
        h0 = hold_cnt;
        start_seq(1, MSEP + 2, MLOW + 2);
        settle();
        chk("R7 blocked no hold", hold_cnt - h0, 0);
        chk("R7 blocked no error", err, exp_err);
        pwrdn = 1'b0;
        repeat (5) @(negedge clk);

        // random sequences against the model
        for (int i = 0; i < 16; i++) begin
            bit first = 1'($urandom_range(0, 1));
            int sep   = $urandom_range(0, 4);
            int width = $urandom_range(3, 8);
            logic [DW-1:0] word = DW'($urandom);
            result = word;
            h0 = hold_cnt; r0 = rd_cnt;
            start_seq(first, sep, width);
            settle();
            if (start_ok(sep, width)) exp_rslt = word;
            else exp_err = err_after(exp_err);
            chk("R2 random hold", hold_cnt - h0, start_ok(sep, width) ? 1 : 0);
            chk("R3 random result", rslt, exp_rslt);
            chk("R5 random errors", err, exp_err);
            chk("R8 random reads", rd_cnt - r0, (first && sep > 0) ? 1 : 0);
        end

        // R9 saturation
        for (int i = 0; i < EMAX + 3; i++) begin
            start_seq(0, 0, 2);
            repeat (6) @(negedge clk);
            exp_err = err_after(exp_err);
        end
        chk("R9 saturated", err, EMAX);
        chk("R9 model saturated", exp_err, EMAX);

        chk("R10 hold pulse shape", hold_bad, 0);
        finish_run();
    end

endmodule